// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Burst Memory

This block is a synchronous single-port memory that accepts a new access on every clock. Reads and writes may be mixed in any order with no idle cycle between them. A read's command is registered on a rising edge, and its word appears on the data bus during the cycle that follows that edge, through a combinational read path. A write's command is registered the same way, but its data and byte selects are sampled on the next enabled edge. The bus therefore carries the write data in exactly the cycle that a read would have used for its output, so the two never collide.

Each access either loads a fresh address or advances a four-beat burst on the two lowest address bits. The burst uses linear or interleaved order, chosen when the burst is loaded. A clock enable freezes the whole block. Three chip enables select the device. An asynchronous output enable and a sleep input float the bus. Write data waits in a one-entry buffer before it reaches the array. A read of the same word in the meantime takes the buffered bytes in place of the stale array bytes.

Top module: `zbt_ft_sram`

## Requirements
- R1: After reset no access is active and `dq` is not driven.
- R2: A read loaded on an enabled edge, with `oe_n` low, drives the stored word on `dq` during the cycle right after that edge.
- R3: A write's data and `byte_wr_n` are sampled on the enabled edge after its command. Only lanes with `byte_wr_n[b]` low are stored, where lane b is `dq[b*9+8:b*9]` and the top bit of each lane is its parity bit. With all selects high, nothing is stored.
- R4: Reads and writes follow each other on consecutive edges in any order. A read of a word whose write is still buffered returns the new bytes for the selected lanes and the array bytes for the other lanes.
- R5: With `load_n` high, an enabled edge advances the burst. In linear order (`order_il`=0 at load) the two low address bits step by one modulo 4, and the upper address bits do not change.
- R6: In interleaved order (`order_il`=1 at load) beat n uses the low bits (start XOR n), for n = 0,1,2,3, and then wraps.
- R7: An advance keeps the read/write type of the loaded access. An advance after a deselect stays deselected.
- R8: A load is an access only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. Otherwise it is a deselect, and `dq` floats in the following cycle.
- R9: `dq` is never driven by the block during a write's data cycle, whatever the state of `oe_n`.
- R10: `oe_n` high floats `dq` at once, with no clock edge needed.
- R11: With `clk_en` low, an edge has no effect. The burst position, the access type, the write buffer and the `dq` output all hold, and a write's data sampling moves to the next enabled edge.
- R12: While `sleep` is high, `dq` floats and loads are treated as deselects. Stored contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| clk_en | input | 1 | High: the edge takes effect; low: the edge is ignored |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Low at load: write; high: read |
| byte_wr_n | input | NB | Per-lane write select, active low, sampled with the write data |
| load_n | input | 1 | Low: load a new address; high: advance the burst |
| addr | input | AW | Word address |
| order_il | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | High: the bus floats and no access is started |
| dq | inout | NB*9 | Bidirectional data bus, 9 bits per lane |

## Verification
The bench runs alternating write/read streams to the same and to adjacent words. These streams separate a read served from the write buffer from a read served from the array. They also show whether write data lands one cycle late or one cycle early. Partial and empty byte-select writes followed by an immediate read show whether the merge works per lane. Bursts written in linear order and read back in interleaved order from a different start expose any error in either address sequence, because each beat carries distinct data. Deselect loads, chip enable variants, clock-enable gaps inside both a read and a write data cycle, sleep, and an output enable dropped in mid-cycle each show whether the bus floats, and whether state holds where it should.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

    // Type of the access currently owning the data bus cycle
    typedef enum logic [1:0] {
        ACC_IDLE = 2'd0,
        ACC_RD   = 2'd1,
        ACC_WR   = 2'd2
    } acc_e;

endpackage

// File: rtl/zbt_burst_ctl.sv
module zbt_burst_ctl
    import zbt_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clk_en,
    input  logic          sleep,
    input  logic          load_n,
    input  logic          we_n,
    input  logic          ce_ok,
    input  logic          order_il,
    input  logic [AW-1:0] addr,
    output acc_e          acc_kind,
    output logic [AW-1:0] acc_addr,
    output logic          burst_il
);

    localparam int HW = AW - 2;

    typedef struct packed {
        acc_e          kind;
        logic [HW-1:0] hi;
        logic [1:0]    start;
        logic [1:0]    beat;
        logic          il;
    } burst_t;

    burst_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clk_en) begin
            if (!load_n) begin
                st_d.hi    = addr[AW-1:2];
                st_d.start = addr[1:0];
                st_d.beat  = 2'd0;
                st_d.il    = order_il;
                if (ce_ok) begin
                    st_d.kind = we_n ? ACC_RD : ACC_WR;
                end else begin
                    st_d.kind = ACC_IDLE;
                end
            end else begin
                st_d.beat = st_q.beat + 2'd1;
            end
            if (sleep) begin
                st_d.kind = ACC_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    logic [1:0] lo_bits;
    assign lo_bits  = st_q.il ? (st_q.start ^ st_q.beat) : (st_q.start + st_q.beat);
    assign acc_kind = st_q.kind;
    assign acc_addr = {st_q.hi, lo_bits};
    assign burst_il = st_q.il;

endmodule

// File: rtl/zbt_wbuf.sv
module zbt_wbuf
    import zbt_pkg::*;
#(
    parameter int AW = 6,
    parameter int NB = 2,
    parameter int LW = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  acc_e             acc_kind,
    input  logic [AW-1:0]    acc_addr,
    input  logic [NB*LW-1:0] bus_in,
    input  logic [NB-1:0]    byte_wr_n,
    input  logic [NB*LW-1:0] arr_word,
    output logic [NB*LW-1:0] rd_word,
    output logic             cm_en,
    output logic [AW-1:0]    cm_addr,
    output logic [NB*LW-1:0] cm_data,
    output logic [NB-1:0]    cm_mask
);

    localparam int DW = NB * LW;

    typedef struct packed {
        logic          valid;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic [NB-1:0] mask;
    } wbuf_t;

    wbuf_t wb_d, wb_q;

    always_comb begin
        wb_d = wb_q;
        if (clk_en) begin
            wb_d.valid = (acc_kind == ACC_WR);
            wb_d.addr  = acc_addr;
            wb_d.data  = bus_in;
            wb_d.mask  = ~byte_wr_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wb_q <= '0;
        end else begin
            wb_q <= wb_d;
        end
    end

    // Drain the buffered write on the next enabled edge
    assign cm_en   = wb_q.valid && clk_en;
    assign cm_addr = wb_q.addr;
    assign cm_data = wb_q.data;
    assign cm_mask = wb_q.mask;

    logic hit;
    assign hit = wb_q.valid && (wb_q.addr == acc_addr);

    for (genvar b = 0; b < NB; b++) begin : g_merge
        assign rd_word[b*LW +: LW] = (hit && wb_q.mask[b]) ? wb_q.data[b*LW +: LW]
                                                           : arr_word[b*LW +: LW];
    end

endmodule

// File: rtl/zbt_mem_array.sv
module zbt_mem_array #(
    parameter int AW = 6,
    parameter int NB = 2,
    parameter int LW = 9
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [NB*LW-1:0] wdata,
    input  logic [NB-1:0]    wmask,
    input  logic [AW-1:0]    raddr,
    output logic [NB*LW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    for (genvar b = 0; b < NB; b++) begin : g_lane
        logic [LW-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (we && wmask[b]) begin
                cells[waddr] <= wdata[b*LW +: LW];
            end
        end

        assign rdata[b*LW +: LW] = cells[raddr];
    end

endmodule

// File: rtl/zbt_ft_sram.sv
module zbt_ft_sram
    import zbt_pkg::*;
#(
    parameter int AW = 6,
    parameter int NB = 2,
    parameter int LW = 9,
    localparam int DW = NB * LW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clk_en,
    input  logic          ce1_n,
    input  logic          ce2,
    input  logic          ce3_n,
    input  logic          we_n,
    input  logic [NB-1:0] byte_wr_n,
    input  logic          load_n,
    input  logic [AW-1:0] addr,
    input  logic          order_il,
    input  logic          oe_n,
    input  logic          sleep,
    inout  wire  [DW-1:0] dq
);

    acc_e          acc_kind;
    logic [AW-1:0] acc_addr;
    logic          burst_il;
    logic          ce_ok;
    logic          drv_en;
    logic [DW-1:0] arr_word;
    logic [DW-1:0] rd_word;
    logic          cm_en;
    logic [AW-1:0] cm_addr;
    logic [DW-1:0] cm_data;
    logic [NB-1:0] cm_mask;

    assign ce_ok = !ce1_n && ce2 && !ce3_n;

    zbt_burst_ctl #(.AW(AW)) u_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_en   (clk_en),
        .sleep    (sleep),
        .load_n   (load_n),
        .we_n     (we_n),
        .ce_ok    (ce_ok),
        .order_il (order_il),
        .addr     (addr),
        .acc_kind (acc_kind),
        .acc_addr (acc_addr),
        .burst_il (burst_il)
    );

    zbt_wbuf #(.AW(AW), .NB(NB), .LW(LW)) u_wbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en    (clk_en),
        .acc_kind  (acc_kind),
        .acc_addr  (acc_addr),
        .bus_in    (dq),
        .byte_wr_n (byte_wr_n),
        .arr_word  (arr_word),
        .rd_word   (rd_word),
        .cm_en     (cm_en),
        .cm_addr   (cm_addr),
        .cm_data   (cm_data),
        .cm_mask   (cm_mask)
    );

    zbt_mem_array #(.AW(AW), .NB(NB), .LW(LW)) u_array (
        .clk   (clk),
        .we    (cm_en),
        .waddr (cm_addr),
        .wdata (cm_data),
        .wmask (cm_mask),
        .raddr (acc_addr),
        .rdata (arr_word)
    );

    // Bus is driven only in a read cycle; write data cycles stay floating
    assign drv_en = (acc_kind == ACC_RD) && !oe_n && !sleep;
    assign dq     = drv_en ? rd_word : {DW{1'bz}};

endmodule

// File: rtl/zbt_ft_sram_chk.sv
module zbt_ft_sram_chk #(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clk_en,
    input logic          ce1_n,
    input logic          ce2,
    input logic          ce3_n,
    input logic          we_n,
    input logic          load_n,
    input logic          sleep,
    input logic          oe_n,
    input logic          drv_en,
    input logic [1:0]    acc_kind,
    input logic [AW-1:0] acc_addr,
    input logic          burst_il
);

    AST_DESEL_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !load_n && (ce1_n || !ce2 || ce3_n)) |=> !drv_en); // R8

    AST_WRITE_DATA_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !load_n && !we_n && !ce1_n && ce2 && !ce3_n && !sleep) |=> !drv_en); // R9

    AST_OE_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !drv_en); // R10

    AST_FROZEN_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> ($stable(acc_addr) && $stable(acc_kind))); // R11

    AST_BURST_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && load_n) |=> (acc_addr[AW-1:2] == $past(acc_addr[AW-1:2]))); // R5

    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && load_n && !burst_il) |=> (acc_addr[1:0] == $past(acc_addr[1:0]) + 2'd1)); // R5

    AST_ADVANCE_KEEPS_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && load_n && !sleep) |=> (acc_kind == $past(acc_kind))); // R7

    AST_SLEEP_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !drv_en); // R12

endmodule

bind zbt_ft_sram zbt_ft_sram_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en   (clk_en),
    .ce1_n    (ce1_n),
    .ce2      (ce2),
    .ce3_n    (ce3_n),
    .we_n     (we_n),
    .load_n   (load_n),
    .sleep    (sleep),
    .oe_n     (oe_n),
    .drv_en   (drv_en),
    .acc_kind (acc_kind),
    .acc_addr (acc_addr),
    .burst_il (burst_il)
);

// File: tb/zbt_ft_sram_tb.sv
`timescale 1ns/1ps
module zbt_ft_sram_tb;

    localparam int AW    = 6;
    localparam int NB    = 2;
    localparam int LW    = 9;
    localparam int DW    = NB * LW;
    localparam int DEPTH = 1 << AW;

    localparam logic [2:0] CE_ON   = 3'b010;  // {ce1_n, ce2, ce3_n}
    localparam logic [2:0] CE_OFF1 = 3'b110;
    localparam logic [2:0] CE_OFF2 = 3'b000;
    localparam logic [2:0] CE_OFF3 = 3'b011;

    localparam logic [DW-1:0] FLOAT = {DW{1'b1}};  // bus pulled high when undriven

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_en = 1'b1;
    logic          ce1_n = 1'b1;
    logic          ce2 = 1'b0;
    logic          ce3_n = 1'b1;
    logic          we_n = 1'b1;
    logic [NB-1:0] byte_wr_n = '1;
    logic          load_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          order_il = 1'b0;
    logic          oe_n = 1'b1;
    logic          sleep = 1'b0;
    logic          tb_en = 1'b0;
    logic [DW-1:0] tb_drv = '0;

    tri1 [DW-1:0] dq_bus;
    assign dq_bus = tb_en ? tb_drv : {DW{1'bz}};

    always #10 clk = ~clk;

    zbt_ft_sram #(.AW(AW), .NB(NB), .LW(LW)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en    (clk_en),
        .ce1_n     (ce1_n),
        .ce2       (ce2),
        .ce3_n     (ce3_n),
        .we_n      (we_n),
        .byte_wr_n (byte_wr_n),
        .load_n    (load_n),
        .addr      (addr),
        .order_il  (order_il),
        .oe_n      (oe_n),
        .sleep     (sleep),
        .dq        (dq_bus)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [DW-1:0] exp_q[$];
    string         tag_q[$];

    // Reference model of the requirements
    logic [DW-1:0] ref_mem [DEPTH];
    int            m_kind  = 0;   // 0 idle, 1 read, 2 write
    logic [AW-3:0] m_hi    = '0;
    logic [1:0]    m_start = '0;
    logic [1:0]    m_beat  = '0;
    logic          m_il    = 1'b0;

    function automatic logic [AW-1:0] m_addr();
        return {m_hi, m_il ? (m_start ^ m_beat) : (m_start + m_beat)};
    endfunction

    task automatic check(input logic [DW-1:0] got, input logic [DW-1:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Monitor: compares each cycle's bus against the queued expectation
    initial begin : monitor
        logic [DW-1:0] e;
        string         t;
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(dq_bus, e, t);
            end
        end
    end

    // Driver: sets this cycle's bus/oe and the command for the next edge
    task automatic step(input bit ld, input bit wr, input logic [AW-1:0] a,
                        input logic [2:0] ces, input bit il, input bit en,
                        input bit oe_off, input bit slp,
                        input logic [DW-1:0] wd, input logic [NB-1:0] bsel,
                        input string tag);
        logic [DW-1:0] e;
        load_n   = !ld;
        we_n     = !wr;
        addr     = a;
        {ce1_n, ce2, ce3_n} = ces;
        order_il = il;
        clk_en   = en;
        oe_n     = oe_off;
        sleep    = slp;
        if (m_kind == 2) begin
            tb_en     = 1'b1;
            tb_drv    = wd;
            byte_wr_n = ~bsel;
            e         = wd;
        end else begin
            tb_en     = 1'b0;
            byte_wr_n = '1;
            if (m_kind == 1 && !oe_off && !slp) e = ref_mem[m_addr()];
            else                                e = FLOAT;
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(posedge clk);
        if (en) begin
            if (m_kind == 2) begin
                for (int b = 0; b < NB; b++) begin
                    if (bsel[b]) ref_mem[m_addr()][b*LW +: LW] = wd[b*LW +: LW];
                end
            end
            if (ld) begin
                m_hi    = a[AW-1:2];
                m_start = a[1:0];
                m_beat  = 2'd0;
                m_il    = il;
                m_kind  = (ces == CE_ON) ? (wr ? 2 : 1) : 0;
            end else begin
                m_beat = m_beat + 2'd1;
            end
            if (slp) m_kind = 0;
        end
        #2;
    endtask

    task automatic go(input bit ld, input bit wr, input logic [AW-1:0] a,
                      input logic [DW-1:0] wd, input logic [NB-1:0] bsel, input string tag);
        step(ld, wr, a, CE_ON, 1'b0, 1'b1, 1'b0, 1'b0, wd, bsel, tag);
    endtask

    task automatic desel(input string tag);
        step(1'b1, 1'b0, '0, CE_OFF1, 1'b0, 1'b1, 1'b0, 1'b0, '0, '0, tag);
    endtask

    localparam logic [DW-1:0] D0 = 18'h0A5C3, D1 = 18'h12345, D2 = 18'h2BEEF;
    localparam logic [DW-1:0] D3 = 18'h1F0E1, D4 = 18'h35A5A, D5 = 18'h0C0DE;
    localparam logic [DW-1:0] JUNK = 18'h2AAAA;
    localparam logic [DW-1:0] W0 = 18'h01111, W1 = 18'h02222, W2 = 18'h03333, W3 = 18'h04444;

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // reset state, then a deselect load
        step(1, 0, 6'd0, CE_OFF1, 0, 1, 0, 0, '0, '0, "R1 idle after reset");
        go(1, 1, 6'd4, '0, 2'b00, "R8 deselect load floats");

        // back-to-back mixes with write buffer bypass
        go(1, 0, 6'd4, D0, 2'b11, "R9 write data cycle bus");
        go(1, 1, 6'd5, '0, 2'b00, "R4 read right after write");
        go(1, 0, 6'd4, D1, 2'b11, "R9 write data after read");
        go(1, 1, 6'd4, '0, 2'b00, "R2 flow-through read from array");
        go(1, 0, 6'd4, D2, 2'b01, "R3 partial write data cycle");
        go(1, 0, 6'd5, '0, 2'b00, "R4 merged lanes on pending write");
        go(1, 1, 6'd6, '0, 2'b00, "R2 read of second word");
        go(1, 1, 6'd6, D3, 2'b11, "R3 full write data");
        go(1, 0, 6'd6, D4, 2'b00, "R3 no-select write data");
        go(1, 1, 6'd10, '0, 2'b00, "R3 no-select write stores nothing");

        // linear write burst from 10, interleaved read burst from 9
        go(0, 0, 6'd0, W0, 2'b11, "R5 burst write beat0");
        go(0, 0, 6'd0, W1, 2'b11, "R5 burst write beat1");
        go(0, 0, 6'd0, W2, 2'b11, "R7 burst write beat2");
        step(1, 0, 6'd9, CE_ON, 1, 1, 0, 0, W3, 2'b11, "R5 burst write beat3");
        go(0, 0, 6'd0, '0, 2'b00, "R6 interleaved beat0");
        go(0, 0, 6'd0, '0, 2'b00, "R6 interleaved beat1");
        go(0, 0, 6'd0, '0, 2'b00, "R6 interleaved beat2");
        go(1, 0, 6'd11, '0, 2'b00, "R6 interleaved beat3");
        go(0, 0, 6'd0, '0, 2'b00, "R5 linear read beat0");
        go(0, 0, 6'd0, '0, 2'b00, "R5 linear read wraps");
        go(0, 0, 6'd0, '0, 2'b00, "R5 linear read beat2");
        go(0, 0, 6'd0, '0, 2'b00, "R7 advance keeps read");
        step(1, 0, 6'd4, CE_OFF2, 0, 1, 0, 0, '0, '0, "R5 burst wraps to start");

        // remaining chip enable patterns and advance after deselect
        step(1, 0, 6'd4, CE_OFF3, 0, 1, 0, 0, '0, '0, "R8 ce2 low floats");
        go(0, 0, 6'd0, '0, 2'b00, "R8 ce3_n high floats");
        go(1, 0, 6'd4, '0, 2'b00, "R7 advance after deselect floats");

        // asynchronous output enable inside a read cycle
        oe_n  = 1'b0;
        tb_en = 1'b0;
        #5;
        check(dq_bus, ref_mem[m_addr()], "R10 read drives with oe_n low");
        oe_n = 1'b1;
        #1;
        check(dq_bus, FLOAT, "R10 bus floats without an edge");
        step(1, 0, 6'd4, CE_OFF1, 0, 1, 1, 0, '0, '0, "R10 oe_n high floats");
        go(1, 0, 6'd4, '0, 2'b00, "R9 oe_n low still floats idle");

        // clock enable freeze during a read and during a write data cycle
        go(1, 0, 6'd8, '0, 2'b00, "R2 read before freeze");
        step(0, 0, 6'd0, CE_ON, 0, 0, 0, 0, '0, '0, "R11 read before frozen edge");
        go(0, 0, 6'd0, '0, 2'b00, "R11 read held across frozen edge");
        go(1, 1, 6'd48, '0, 2'b00, "R11 advance resumes");
        step(1, 0, 6'd0, CE_OFF1, 0, 0, 0, 0, JUNK, 2'b11, "R11 write data before frozen edge");
        go(1, 0, 6'd48, D5, 2'b11, "R11 extended write data cycle");
        desel("R11 write took the later data");

        // sleep
        step(1, 0, 6'd4, CE_ON, 0, 1, 0, 1, '0, '0, "R12 sleep idle floats");
        step(1, 1, 6'd4, CE_ON, 0, 1, 0, 1, '0, '0, "R12 read load ignored");
        step(1, 0, 6'd0, CE_OFF1, 0, 1, 0, 1, '0, '0, "R12 write load ignored");
        go(1, 0, 6'd4, '0, 2'b00, "R12 wake idle");
        desel("R12 contents kept");
        desel("R8 final deselect");

        repeat (3) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R1 watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule